// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is the slave side of a byte-wide serial EEPROM on a four-wire SPI link. A host lowers chip select and shifts in an 8-bit opcode. Some opcodes are followed by a 16-bit address and data bytes. Read traffic returns bytes from an internal array. Write traffic is collected into a small page buffer and is committed only when chip select rises after a whole number of bytes. A commit opens a timed busy window. During that window the buffered bytes drain into the array, and afterwards the write-enable latch clears itself.

All four SPI pins are oversampled by the system clock through synchronizer stages, so the serial clock must be much slower than the system clock. There is no streaming data interface at the block edge: the only data path is the serial link itself. The block reports state to the host through a status byte. A two-bit protection code in that byte selects an upper portion of the address space, or all of it, in which writes are silently discarded.

The storage array has 2^MEM_AW bytes. The 15-bit address is folded onto it by keeping its low MEM_AW bits, so higher addresses alias. Block protection is always decoded on the full 15-bit address.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch is visible as status bit 1.
- R2: Opcode 0x05 returns the status byte on every following byte slot. Bit 7 is the protect-enable flag, bits 6..4 always read 0, bits 3..2 are the protection code, bit 1 is the write-enable latch and bit 0 is the busy flag. All bits are 0 after reset.
- R3: Opcode 0x03 takes a 16-bit address, sent MSB first, and uses only its low 15 bits. It then returns data MSB first, with the address advancing by one after each byte. An unwritten location reads 0xFF.
- R4: Opcode 0x02 takes the same address format and then data bytes. It is accepted only while the write-enable latch is 1. Otherwise nothing is stored and no busy window starts.
- R5: A write commits only when chip select rises with the bit count on a byte boundary. A transfer ending mid-byte discards the whole write and leaves the latch unchanged.
- R6: After a commit, the busy bit reads 1 for WR_CYCLES system clocks and then 0. The write-enable latch reads 0 once busy falls.
- R7: Protection code 00 protects nothing, 01 protects 0x6000..0x7FFF, 10 protects 0x4000..0x7FFF and 11 protects the whole range. Bytes aimed at protected addresses are dropped, and the other bytes of the same burst are still written.
- R8: While busy, every opcode other than 0x05 is ignored. An ignored read returns 0x00, and an ignored write changes nothing.
- R9: Opcode 0x01 followed by one byte needs the write-enable latch. On commit it loads bits 7 and 3..2 from that byte and starts a busy window.
- R10: The block uses SPI mode 0. MOSI is sampled on the rising SCK edge and MISO changes after the falling edge. MISO is 0 while chip select is high.
- R11: A write burst stores at most BUF_BYTES bytes. Any further bytes in the same burst are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |

## Verification
The assertions rely on the host keeping each SCK phase at least several system clocks long. This gives a captured byte time to reach the command logic before the next falling edge reloads the output shifter. They also rely on SCK being low whenever chip select changes, and on chip select never moving within half an SCK period of an SCK edge. The stimulus holds every SCK phase for eight system clocks, changes MOSI only while SCK is low, and leaves a half-period gap on both sides of every chip select edge. Under those conditions the checks on the busy window, the latch release and protected drains hold.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  localparam int ADDR_W = 15;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_RD, ST_WR, ST_SRW, ST_SRR, ST_SKIP
  } cmd_state_e;

  // Protected region selected by the two-bit code
  function automatic logic addr_locked(input logic [1:0] code, input logic [ADDR_W-1:0] a);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return a[14:13] == 2'b11;
      2'b10:   return a[14];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_eeprom_pinsync.sv
module spi_eeprom_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_end,
  output logic mosi_s
);
  // bit 0: sck, bit 1: cs_n, bit 2: mosi
  localparam logic [2:0] IDLE_VAL = 3'b010;

  logic [2:0] stg [STAGES];
  logic [2:0] prev;
  logic [2:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE_VAL;
      prev <= IDLE_VAL;
    end else begin
      stg[0] <= {mosi, cs_n, sck};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign cur      = stg[STAGES-1];
  assign sck_rise = cur[0] & ~prev[0];
  assign sck_fall = ~cur[0] & prev[0];
  assign cs_act   = ~cur[1];
  assign cs_end   = cur[1] & ~prev[1];
  assign mosi_s   = cur[2];
endmodule

// File: rtl/spi_eeprom_shifter.sv
module spi_eeprom_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       mosi_s,
  input  logic [7:0] tx_next,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       aligned,
  output logic       miso
);
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else if (!cs_act) begin
      bit_cnt  <= '0;
      tx_sr    <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sck_rise) begin
        rx_sr   <= {rx_sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_valid <= 1'b1;
          rx_byte  <= {rx_sr, mosi_s};
        end
      end
      if (sck_fall) begin
        if (bit_cnt == 3'd0) tx_sr <= tx_next;
        else                 tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  assign aligned = (bit_cnt == 3'd0);
  assign miso    = cs_act & tx_sr[7];
endmodule

// File: rtl/spi_eeprom_mem.sv
module spi_eeprom_mem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[wa] <= wd;
    end
  end

  assign rd = cells[ra];
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int MEM_AW    = 8,
  parameter int BUF_BYTES = 8,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_end,
  input  logic              rx_valid,
  input  logic              aligned,
  input  logic [7:0]        rx_byte,
  input  logic [7:0]        rd_data,
  output logic [7:0]        tx_next,
  output logic [7:0]        status,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_wa,
  output logic [7:0]        mem_wd,
  output logic [MEM_AW-1:0] rd_addr
);
  localparam int IDX_W = $clog2(BUF_BYTES + 1);
  localparam int SEL_W = $clog2(BUF_BYTES);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [IDX_W-1:0] BUF_LIM  = IDX_W'(BUF_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);

  cmd_state_e        state;
  logic              rd_cmd;
  logic [ADDR_W-1:0] addr;
  logic              wpen, wel, busy, sr_pend;
  logic [1:0]        bp;
  logic [7:0]        sr_new;
  logic [CNT_W-1:0]  busy_cnt;
  logic [IDX_W-1:0]  buf_cnt, drain_idx;

  logic [7:0]          buf_dat [BUF_BYTES];
  logic [ADDR_W-1:0]   buf_adr [BUF_BYTES];
  logic [BUF_BYTES-1:0] buf_ok;

  logic [SEL_W-1:0] drain_sel, fill_sel;
  logic             commit_wr, commit_sr, fill_en, draining;

  assign status    = {wpen, 3'b000, bp, wel, busy};
  assign drain_sel = SEL_W'(drain_idx);
  assign fill_sel  = SEL_W'(buf_cnt);
  assign rd_addr   = addr[MEM_AW-1:0];

  assign commit_wr = cs_end && aligned && !busy && (state == ST_WR) && (buf_cnt != '0);
  assign commit_sr = cs_end && aligned && !busy && sr_pend;
  assign fill_en   = rx_valid && (state == ST_WR) && (buf_cnt < BUF_LIM);
  assign draining  = busy && (drain_idx < buf_cnt);

  assign mem_we = draining && buf_ok[drain_sel];
  assign mem_wa = buf_adr[drain_sel];
  assign mem_wd = buf_dat[drain_sel];

  always_comb begin
    case (state)
      ST_SRR:  tx_next = status;
      ST_RD:   tx_next = rd_data;
      default: tx_next = 8'h00;
    endcase
  end

  // Page buffer contents (no reset: only read below buf_cnt)
  always_ff @(posedge clk) begin
    if (fill_en) begin
      buf_dat[fill_sel] <= rx_byte;
      buf_adr[fill_sel] <= addr;
      buf_ok[fill_sel]  <= !addr_locked(bp, addr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OPC;
      rd_cmd    <= 1'b0;
      addr      <= '0;
      wpen      <= 1'b0;
      wel       <= 1'b0;
      busy      <= 1'b0;
      bp        <= 2'b00;
      sr_pend   <= 1'b0;
      sr_new    <= '0;
      busy_cnt  <= '0;
      buf_cnt   <= '0;
      drain_idx <= '0;
    end else begin
      // timed write window
      if (busy) begin
        if (draining) drain_idx <= drain_idx + 1'b1;
        if (busy_cnt == '0) begin
          busy    <= 1'b0;
          wel     <= 1'b0;
          buf_cnt <= '0;
        end else begin
          busy_cnt <= busy_cnt - 1'b1;
        end
      end

      if (cs_end) begin
        state   <= ST_OPC;
        sr_pend <= 1'b0;
        if (commit_wr || commit_sr) begin
          busy      <= 1'b1;
          busy_cnt  <= CNT_LAST;
          drain_idx <= '0;
        end
        if (commit_sr) begin
          wpen <= sr_new[7];
          bp   <= sr_new[3:2];
        end
        if (!busy && !commit_wr) buf_cnt <= '0;
      end else if (rx_valid) begin
        case (state)
          ST_OPC: begin
            if (busy && rx_byte != OP_RDSR) begin
              state <= ST_SKIP;
            end else begin
              case (rx_byte)
                OP_WREN:  begin wel <= 1'b1; state <= ST_SKIP; end
                OP_WRDI:  begin wel <= 1'b0; state <= ST_SKIP; end
                OP_RDSR:  state <= ST_SRR;
                OP_WRSR:  state <= wel ? ST_SRW : ST_SKIP;
                OP_READ:  begin rd_cmd <= 1'b1; state <= ST_AHI; end
                OP_WRITE: begin
                  rd_cmd  <= 1'b0;
                  buf_cnt <= '0;
                  state   <= wel ? ST_AHI : ST_SKIP;
                end
                default:  state <= ST_SKIP;
              endcase
            end
          end
          ST_AHI: begin
            addr[14:8] <= rx_byte[6:0];
            state      <= ST_ALO;
          end
          ST_ALO: begin
            addr[7:0] <= rx_byte;
            state     <= rd_cmd ? ST_RD : ST_WR;
          end
          ST_RD: addr <= addr + 1'b1;
          ST_WR: begin
            addr <= addr + 1'b1;
            if (fill_en) buf_cnt <= buf_cnt + 1'b1;
          end
          ST_SRW: begin
            sr_new  <= rx_byte;
            sr_pend <= 1'b1;
            state   <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_eeprom_pkg::*;
#(
  parameter int MEM_AW      = 8,
  parameter int BUF_BYTES   = 8,
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  logic              sck_rise, sck_fall, cs_act, cs_end, mosi_s;
  logic              rx_valid, aligned;
  logic [7:0]        rx_byte, tx_next, status, rd_data, mem_wd;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_wa;
  logic [MEM_AW-1:0] rd_addr;

  spi_eeprom_pinsync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
    .cs_end(cs_end), .mosi_s(mosi_s)
  );

  spi_eeprom_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .tx_next(tx_next),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .aligned(aligned), .miso(miso)
  );

  spi_eeprom_ctrl #(
    .MEM_AW(MEM_AW), .BUF_BYTES(BUF_BYTES), .WR_CYCLES(WR_CYCLES)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cs_end(cs_end), .rx_valid(rx_valid),
    .aligned(aligned), .rx_byte(rx_byte), .rd_data(rd_data),
    .tx_next(tx_next), .status(status), .mem_we(mem_we), .mem_wa(mem_wa),
    .mem_wd(mem_wd), .rd_addr(rd_addr)
  );

  spi_eeprom_mem #(.AW(MEM_AW)) mem_i (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .wa(mem_wa[MEM_AW-1:0]),
    .wd(mem_wd), .ra(rd_addr), .rd(rd_data)
  );
endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk
  import spi_eeprom_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        status,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_wa,
  input logic              cs_end
);
  // R6
  latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);

  // R7
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !addr_locked(status[3:2], mem_wa));

  // R5
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(cs_end));

  // R8
  latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> !$past(status[0]));

  // R6
  drain_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> status[0]);
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .status(status), .mem_we(mem_we),
  .mem_wa(mem_wa), .cs_end(cs_end)
);

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WRC        = 2000;
  localparam int BUFN       = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_slave #(.MEM_AW(8), .BUF_BYTES(BUFN), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    @(negedge clk);
    cs_n = 1'b0;
    clocks(HALF);
  endtask

  task automatic cs_hi();
    clocks(HALF);
    cs_n = 1'b1;
    clocks(4 * HALF);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      clocks(HALF);
      rx[i] = miso;
      sck = 1'b1;
      clocks(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); xb(op, d); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    cs_lo(); xb(8'h05, d); xb(8'h00, st); cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xb(8'h01, d); xb(v, d); cs_hi();
  endtask

  task automatic read1(input logic [15:0] a, output logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xb(8'h03, d); xb(a[15:8], d); xb(a[7:0], d); xb(8'h00, v); cs_hi();
  endtask

  task automatic write_open(input logic [15:0] a);
    logic [7:0] d;
    cs_lo(); xb(8'h02, d); xb(a[15:8], d); xb(a[7:0], d);
  endtask

  task automatic settle();
    clocks(WRC + 200);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [7:0] st;
    check("R10 miso idle", {7'd0, miso}, 8'h00);
    rdsr(st);
    check("R2 reset status", st, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] st;
    cmd1(8'h06); rdsr(st);
    check("R1 set latch", st, 8'h02);
    cmd1(8'h04); rdsr(st);
    check("R1 clear latch", st, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] d, st;
    read1(16'h0005, d);
    check("R3 erased", d, 8'hFF);
    cmd1(8'h06);
    write_open(16'h0010); xb(8'hAA, d); xb(8'h55, d); xb(8'hC3, d); cs_hi();
    rdsr(st);
    check("R6 busy after commit", st, 8'h03);
    settle();
    rdsr(st);
    check("R6 busy done latch clear", st, 8'h00);
    cs_lo(); xb(8'h03, d); xb(8'h00, d); xb(8'h10, d);
    xb(8'h00, d); check("R3 burst b0", d, 8'hAA);
    xb(8'h00, d); check("R3 burst b1", d, 8'h55);
    xb(8'h00, d); check("R3 burst b2", d, 8'hC3);
    cs_hi();
    check("R10 miso low after cs", {7'd0, miso}, 8'h00);
    read1(16'h8011, d);
    check("R3 top address bit unused", d, 8'h55);
  endtask

  task automatic t_no_latch();
    logic [7:0] d, st;
    write_open(16'h0020); xb(8'h5A, d); cs_hi();
    rdsr(st);
    check("R4 no busy without latch", st, 8'h00);
    read1(16'h0020, d);
    check("R4 nothing stored", d, 8'hFF);
  endtask

  task automatic t_partial();
    logic [7:0] d, st;
    cmd1(8'h06);
    write_open(16'h0030); xb(8'h66, d); xbits(8'hE0, 3, d); cs_hi();
    rdsr(st);
    check("R5 partial no commit", st, 8'h02);
    read1(16'h0030, d);
    check("R5 partial discarded", d, 8'hFF);
    cmd1(8'h04);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d, st;
    cmd1(8'h06);
    write_open(16'h0010); xb(8'h11, d); cs_hi();
    read1(16'h0011, d);
    check("R8 read ignored while busy", d, 8'h00);
    write_open(16'h0011); xb(8'hEE, d); cs_hi();
    settle();
    read1(16'h0010, d);
    check("R8 committed byte", d, 8'h11);
    read1(16'h0011, d);
    check("R8 write ignored while busy", d, 8'h55);
    rdsr(st);
    check("R8 status idle", st, 8'h00);
  endtask

  task automatic t_status_write();
    logic [7:0] st;
    cmd1(8'h06); wrsr(8'hFC);
    rdsr(st);
    check("R9 status commit busy", st, 8'h8F);
    settle();
    rdsr(st);
    check("R9 R2 status fields", st, 8'h8C);
    wrsr(8'h00);
    rdsr(st);
    check("R9 needs latch", st, 8'h8C);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    cmd1(8'h06);
    write_open(16'h0050); xb(8'h77, d); cs_hi(); settle();
    read1(16'h0050, d);
    check("R7 code 11 drops", d, 8'hFF);
    cmd1(8'h06); wrsr(8'h04); settle();
    cmd1(8'h06);
    write_open(16'h5FFF); xb(8'h12, d); xb(8'h34, d); cs_hi(); settle();
    read1(16'h5FFF, d);
    check("R7 code 01 below", d, 8'h12);
    read1(16'h6000, d);
    check("R7 code 01 dropped", d, 8'hFF);
    cmd1(8'h06); wrsr(8'h08); settle();
    cmd1(8'h06);
    write_open(16'h3FFF); xb(8'h9A, d); xb(8'hBC, d); cs_hi(); settle();
    read1(16'h3FFF, d);
    check("R7 code 10 below", d, 8'h9A);
    read1(16'h4000, d);
    check("R7 code 10 dropped", d, 8'hFF);
    cmd1(8'h06); wrsr(8'h00); settle();
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    cmd1(8'h06);
    write_open(16'h0080);
    for (int i = 0; i < BUFN + 2; i++) xb(8'h80 + 8'(i), d);
    cs_hi(); settle();
    cs_lo(); xb(8'h03, d); xb(8'h00, d); xb(8'h80, d);
    for (int i = 0; i < BUFN + 2; i++) begin
      xb(8'h00, d);
      check("R11 page limit", d, (i < BUFN) ? 8'h80 + 8'(i) : 8'hFF);
    end
    cs_hi();
  endtask

  initial begin
    clocks(5);
    rst_n = 1'b1;
    clocks(5);
    t_reset();
    t_latch();
    t_write_read();
    t_no_latch();
    t_partial();
    t_busy_ignore();
    t_status_write();
    t_protect();
    t_overflow();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule